// File: doc/BRIEF.md
# Expansion Bus Arbiter for Cascaded Repeaters

This block arbitrates a shared expansion bus that joins several repeater devices into one logical repeater. Each device raises its request line while one of its ports is receiving. The arbiter samples every request on the rising system clock edge and returns two signals common to all devices. The acknowledge signal means that at least one device is active. The collision signal means that more than one device is active in the same sample.

Each device also has a bidirectional jam line, and the arbiter tells each device which way that line points. Without an acknowledge, every jam line is left floating. A device that requested and sees the acknowledge drives its jam line. A device that sees the acknowledge without requesting listens on its jam line. The direction outputs combine the live request with the registered acknowledge. The device count `N` may be set from 2 to 8. The interface carries no data stream, so all pins are plain control levels and none uses a handshake.

Top module: `exp_bus_arbiter`

## Requirements
- R1: `ack` is registered. After each rising clock edge out of reset it is 1 exactly when at least one bit of `req` was 1 at that edge.
- R2: `col` is registered. After each rising clock edge out of reset it is 1 exactly when two or more bits of `req` were 1 at that edge.
- R3: While `ack` is 0, every device's jam line is high impedance: `jam_oe[i]` = 0 and `jam_ie[i]` = 0 for every i.
- R4: While `ack` is 1 and `req[i]` is 1, device i drives its jam line: `jam_oe[i]` = 1 and `jam_ie[i]` = 0.
- R5: While `ack` is 1 and `req[i]` is 0, device i listens on its jam line: `jam_oe[i]` = 0 and `jam_ie[i]` = 1.
- R6: A synchronous active-low reset (`rst_n` = 0 at a rising edge) clears `ack` and `col`, whatever `req` holds. As a result, every jam line is high impedance.
- R7: The latency is one cycle. A request that lasts one sampled cycle produces an `ack` that lasts exactly one cycle, starting one edge later.
- R8: `col` is never 1 while `ack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N | Per-device bus request, active high |
| ack | output | 1 | Registered common acknowledge |
| col | output | 1 | Registered common collision |
| jam_oe | output | N | Per-device jam drive enable (device outputs on its jam line) |
| jam_ie | output | N | Per-device jam listen enable (device treats its jam line as input) |

## Verification
The assertions assume that `req` is a clean two-valued level that is stable around each rising clock edge. They also assume that `rst_n` is held low from time zero until after the first edge. The bench changes `req` only on falling clock edges and asserts reset before the first rising edge. It then walks every request combination for four devices, in an order that passes through idle, single and collision cases. It checks the jam direction outputs both before and after each sampling edge, so the mix of a live request and the previous acknowledge is covered.

// File: rtl/exp_arb_pkg.sv
package exp_arb_pkg;

  // Direction code for one device's jam line
  typedef enum logic [1:0] {
    JAM_HIZ    = 2'b00,
    JAM_DRIVE  = 2'b01,
    JAM_LISTEN = 2'b10
  } jam_dir_e;

  localparam int unsigned MIN_DEV = 2;
  localparam int unsigned MAX_DEV = 8;

endpackage

// File: rtl/exp_req_count.sv
module exp_req_count #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req,
  output logic         any_req,
  output logic         multi_req
);

  localparam int unsigned CW = $clog2(N + 1);

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(req[i]);
    end
  end

  assign any_req   = (cnt != '0);
  assign multi_req = (cnt > CW'(1));

endmodule

// File: rtl/exp_grant_reg.sv
module exp_grant_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  input  logic multi_req,
  output logic ack,
  output logic col
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0;
      col <= 1'b0;
    end else begin
      ack <= any_req;
      col <= multi_req;
    end
  end

endmodule

// File: rtl/exp_jam_dir.sv
module exp_jam_dir
  import exp_arb_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic         ack,
  input  logic [N-1:0] req,
  output logic [N-1:0] jam_oe,
  output logic [N-1:0] jam_ie
);

  for (genvar g = 0; g < N; g++) begin : g_dev
    jam_dir_e dir;

    always_comb begin
      if (!ack)        dir = JAM_HIZ;
      else if (req[g]) dir = JAM_DRIVE;
      else             dir = JAM_LISTEN;
    end

    assign jam_oe[g] = (dir == JAM_DRIVE);
    assign jam_ie[g] = (dir == JAM_LISTEN);
  end

endmodule

// File: rtl/exp_bus_arbiter.sv
module exp_bus_arbiter #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic         ack,
  output logic         col,
  output logic [N-1:0] jam_oe,
  output logic [N-1:0] jam_ie
);

  logic any_req;
  logic multi_req;

  exp_req_count #(.N(N)) u_count (
    .req       (req),
    .any_req   (any_req),
    .multi_req (multi_req)
  );

  exp_grant_reg u_grant (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_req   (any_req),
    .multi_req (multi_req),
    .ack       (ack),
    .col       (col)
  );

  exp_jam_dir #(.N(N)) u_dir (
    .ack    (ack),
    .req    (req),
    .jam_oe (jam_oe),
    .jam_ie (jam_ie)
  );

endmodule

// File: rtl/exp_bus_arbiter_chk.sv
module exp_bus_arbiter_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic         ack,
  input logic         col,
  input logic [N-1:0] jam_oe,
  input logic [N-1:0] jam_ie
);

  logic armed;

  always_ff @(posedge clk) begin
    armed <= rst_n;
  end

  // R1
  ack_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed === 1'b1) |-> (ack == ($past(req) != '0)));

  // R2
  col_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed === 1'b1) |-> (col == ($countones($past(req)) > 1)));

  // R3
  hiz_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (jam_oe == '0 && jam_ie == '0));

  // R4
  drive_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ((jam_oe & req) == req && (jam_ie & req) == '0));

  // R5
  listen_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ((jam_ie & ~req) == ~req && (jam_oe & ~req) == '0));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!ack && !col));

  // R8
  col_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col |-> ack);

endmodule

bind exp_bus_arbiter exp_bus_arbiter_chk #(.N(N)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req    (req),
  .ack    (ack),
  .col    (col),
  .jam_oe (jam_oe),
  .jam_ie (jam_ie)
);

// File: tb/sim_exp_bus_arbiter.sv
module sim_exp_bus_arbiter;

  localparam int unsigned NDEV = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NDEV-1:0] req = '1;
  logic            ack;
  logic            col;
  logic [NDEV-1:0] jam_oe;
  logic [NDEV-1:0] jam_ie;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit exp_ack = 1'b0;
  bit exp_col = 1'b0;

  always #10 clk = ~clk;

  exp_bus_arbiter #(.N(NDEV)) u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .ack    (ack),
    .col    (col),
    .jam_oe (jam_oe),
    .jam_ie (jam_ie)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_dir(input string when);
    logic [NDEV-1:0] eo, ei;
    eo = exp_ack ? req : '0;
    ei = exp_ack ? ~req : '0;
    check(jam_oe === eo, exp_ack ? {"R4 jam_oe ", when} : {"R3 jam_oe ", when},
          32'(jam_oe), 32'(eo));
    check(jam_ie === ei, exp_ack ? {"R5 jam_ie ", when} : {"R3 jam_ie ", when},
          32'(jam_ie), 32'(ei));
  endtask

  // Drive a request vector on a falling edge; check before and after the sampling edge
  task automatic apply(input logic [NDEV-1:0] v);
    @(negedge clk);
    req = v;
    #2;
    check(ack === exp_ack, "R1 ack held before edge", 32'(ack), 32'(exp_ack));
    check_dir("pre-edge");
    @(posedge clk);
    #2;
    exp_ack = (v != '0);
    exp_col = ($countones(v) > 1);
    check(ack === exp_ack, "R1 ack after edge", 32'(ack), 32'(exp_ack));
    check(col === exp_col, "R2 col after edge", 32'(col), 32'(exp_col));
    check(!(col && !ack), "R8 col without ack", 32'(col), 32'(ack));
    check_dir("post-edge");
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #2;
    check(ack === 1'b0, "R6 ack in reset", 32'(ack), 0);
    check(col === 1'b0, "R6 col in reset", 32'(col), 0);
    check(jam_oe === '0, "R6 jam_oe in reset", 32'(jam_oe), 0);
    check(jam_ie === '0, "R6 jam_ie in reset", 32'(jam_ie), 0);
    @(negedge clk);
    req = '0;
    rst_n = 1'b1;
    exp_ack = 1'b0;
    exp_col = 1'b0;
  endtask

  task automatic t_all_combos();
    for (int v = 0; v < (1 << NDEV); v++) begin
      apply(NDEV'(v));
    end
    apply('0);
  endtask

  task automatic t_single_pulse();
    apply(NDEV'(1));
    check(ack === 1'b1, "R7 pulse ack rises", 32'(ack), 1);
    apply('0);
    check(ack === 1'b0, "R7 pulse ack falls", 32'(ack), 0);
  endtask

  task automatic t_collision_to_single();
    apply('1);
    check(col === 1'b1, "R2 full collision", 32'(col), 1);
    apply(NDEV'(4));
    check(col === 1'b0, "R2 collision clears", 32'(col), 0);
    check(jam_oe === NDEV'(4), "R4 lone driver", 32'(jam_oe), 4);
    apply('0);
  endtask

  task automatic t_reset_midframe();
    apply('1);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #2;
    check(ack === 1'b0 && col === 1'b0, "R6 reset during collision",
          32'({ack, col}), 0);
    check(jam_oe === '0 && jam_ie === '0, "R6 hi-Z after reset",
          32'({jam_oe, jam_ie}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    req = '0;
    exp_ack = 1'b0;
    exp_col = 1'b0;
    apply('0);
  endtask

  initial begin
    t_reset();
    t_all_combos();
    t_single_pulse();
    t_collision_to_single();
    t_reset_midframe();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule